// File: doc/BRIEF.md
# Cartridge Bank-Control Register File

This block is the register file of an 8-bit home-computer expansion cartridge. It sits on the CPU's I/O window of 512 bytes, which is split into a first and a second 256-byte page. It decodes CPU reads and writes to a small set of control registers and enforces the lock and mode rules between them. It holds the persistent state that a separate address decoder uses to map the cartridge memories: the GAME and EXROM lines, bank address bits 13 to 18, the ROM/RAM select, the 16K mapping mode and the freeze state.

Two control registers sit at the bottom of the first page. A bank-mode group of three registers sits in the second page at offsets 0x111 to 0x113: a card-control register, a status/mode register and an extended bank register. A freeze button forces the cartridge into freeze mode on its rising edge. Freeze clears part of the bank state and forces RAM on until software leaves freeze. Reset and the button are plain synchronous inputs. Reads are combinational. `rdHit` tells the surrounding bus whether a register answered, so a hidden register leaves its address to the I/O underneath.

Top module: `cart_bank_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register. After reset `gameLine`, `exromLine`, `ramOn`, `freezeActive`, `bankingLive`, `freezeOff`, `mmcOff` and `bankAddr` are 0, `flashWrEn` is 1, and a status read (0x112) returns 0x00.
- R2: The main control register (0x000) and the extension register (0x001) answer reads and accept writes only while the register-enable bit is 1 and the cartridge-off bit is 0. Otherwise `rdHit` is 0 for them and their writes change nothing.
- R3: A write to 0x000 sets these fields: GAME from bit0, EXROM from bit1, cartridge-off from bit2, bank bits 13/14/15 from bits 3/4/7, and RAM select from bit5. A read of 0x000 returns bit0 = flash write enabled, bit1 = I/O banking enable, bit2 = the button level sampled at the last edge, bits 3/4/7 = bank bits 13/14/15, bit5 = 0 and bit6 = the I/O-window-low bit.
- R4: A write to 0x001 sets these fields: clock-port enable from bit0, I/O banking from bit1, freeze-off from bit2, I/O-window-low from bit6, and the same bank bits 13/14/15 from bits 3/4/7. Reads of 0x000 and 0x001 return the same value.
- R5: The register-group-off bit (bit5 of 0x001) changes only while extended mode is 1. While that bit is 1, the registers at 0x111 to 0x113 give `rdHit` 0 and ignore writes.
- R6: The extended bank register (0x113) is reached only while extended mode is 1. It holds bank bits 16 to 18 in bits 0 to 2, the 16K mode in bit5 and the register enable in bit6. Its other bits read 0.
- R7: A write to 0x112 with bit0 set forbids flash writes: `flashWrEn` goes to 0 and stays 0 until reset, whatever is written after.
- R8: A write to 0x112 sets extended mode from bit6. Writing bit6 as 1 also clears the cartridge-off bit.
- R9: When the button rises while freeze is enabled and not active, `freezeActive` is 1 after that edge. Bank bits 13 to 15 and RAM select are cleared, bank bits 16 to 18 and the card-control RAM-mode bit keep their values, and `ramOn` is forced to 1. If a control write arrives in the same cycle, freeze entry wins and the write is dropped.
- R10: The button has no effect while freeze-off is 1, while freeze is already active, or while it is held high with no new rising edge.
- R11: A write to 0x000 with bit6 set leaves freeze mode. Freeze is otherwise held.
- R12: While banking is not live (register enable 0 or cartridge-off 1), `gameLine`, `exromLine`, `ramOn` and `bankAddr` are all 0.
- R13: While the 16K mode bit is 1, `bankAddr[0]` (bank bit 13) is driven 0. The stored bit is unchanged and still reads back.
- R14: A status read returns GAME in bit1 and EXROM in bit2, and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioSel | input | 1 | CPU access to the I/O window this cycle |
| ioWr | input | 1 | Write access |
| ioRd | input | 1 | Read access |
| ioAddr | input | 9 | Offset in the 512-byte I/O window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0 when no register answers |
| rdHit | output | 1 | A visible register answered the read |
| freezeBtn | input | 1 | Freeze button level, synchronous |
| gameLine | output | 1 | GAME line drive |
| exromLine | output | 1 | EXROM line drive |
| bankAddr | output | 6 | Bank address bits 13 (bit0) to 18 (bit5) |
| ramOn | output | 1 | RAM selected instead of ROM |
| freezeActive | output | 1 | Freeze mode active |
| flashWrEn | output | 1 | Flash writes allowed |
| bankingLive | output | 1 | Banking enabled and cartridge logic on |
| cartOff | output | 1 | Cartridge-off bit |
| clockPortEn | output | 1 | Clock-port window enabled |
| ioBankEn | output | 1 | I/O RAM banking enabled |
| freezeOff | output | 1 | Freeze button disabled |
| mmcOff | output | 1 | Register group at 0x111 to 0x113 hidden |
| ioWinLow | output | 1 | I/O memory window in the first page |
| map16k | output | 1 | 16K mapping mode |
| ramMode | output | 1 | Card-control RAM-mode bit (0x111 bit5) |
| biosOff | output | 1 | Card-control boot-ROM-off bit (0x111 bit0) |

## Verification
A write presented in the cycle before a rising edge shows at the outputs and on read-back right after that edge, and reads are due in the same cycle they are presented. A rising button level seen at an edge sets freeze at that same edge. The bench therefore drives every access and button change at a falling edge and samples one falling edge later. Combinational reads are sampled 1 ns after they are driven, inside the low phase. The sweeps cover all 256 values of both control registers, with the expected fields worked out bit by bit in the bench.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_CARD,
    RD_STAT,
    RD_BANK
  } rdSel_e;

  typedef struct packed {
    logic wrMain;
    logic wrExt;
    logic wrCard;
    logic wrStat;
    logic wrBank;
    logic freezeGo;
  } strobes_t;

endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] MAIN_ADR = 'h000,
  parameter logic [ADDR_W-1:0] CARD_ADR = 'h111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ioSel,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              freezeBtn,
  input  logic              cartOff,
  input  logic              regEnable,
  input  logic              mmcOff,
  input  logic              extMode,
  input  logic              freezeOff,
  input  logic              freezeActive,
  output strobes_t          strobe,
  output rdSel_e            rdSel,
  output logic              btnLevel
);

  localparam logic [ADDR_W-1:0] EXT_ADR  = ADDR_W'(MAIN_ADR + 1);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(CARD_ADR + 1);
  localparam logic [ADDR_W-1:0] BANK_ADR = ADDR_W'(CARD_ADR + 2);

  logic btnPrev;
  logic ctrlVis, groupVis, bankVis;
  logic hitMain, hitExt, hitCard, hitStat, hitBank;
  logic wrCyc, rdCyc, freezeGo;

  always_ff @(posedge clk) begin
    if (rst) btnPrev <= 1'b0;
    else     btnPrev <= freezeBtn;
  end

  assign btnLevel = btnPrev;

  always_comb begin
    ctrlVis  = regEnable & ~cartOff;
    groupVis = ~mmcOff;
    bankVis  = groupVis & extMode;
    hitMain  = ctrlVis  & (ioAddr == MAIN_ADR);
    hitExt   = ctrlVis  & (ioAddr == EXT_ADR);
    hitCard  = groupVis & (ioAddr == CARD_ADR);
    hitStat  = groupVis & (ioAddr == STAT_ADR);
    hitBank  = bankVis  & (ioAddr == BANK_ADR);
    wrCyc    = ioSel & ioWr;
    rdCyc    = ioSel & ioRd;
    freezeGo = freezeBtn & ~btnPrev & ~freezeOff & ~freezeActive;
  end

  always_comb begin
    strobe.freezeGo = freezeGo;
    strobe.wrMain   = wrCyc & hitMain & ~freezeGo;
    strobe.wrExt    = wrCyc & hitExt  & ~freezeGo;
    strobe.wrCard   = wrCyc & hitCard;
    strobe.wrStat   = wrCyc & hitStat;
    strobe.wrBank   = wrCyc & hitBank;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdCyc) begin
      if (hitMain || hitExt) rdSel = RD_CTRL;
      else if (hitCard)      rdSel = RD_CARD;
      else if (hitStat)      rdSel = RD_STAT;
      else if (hitBank)      rdSel = RD_BANK;
    end
  end

endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath
  import cart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobe,
  input  rdSel_e            rdSel,
  input  logic              btnLevel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              gameLine,
  output logic              exromLine,
  output logic [5:0]        bankAddr,
  output logic              ramOn,
  output logic              freezeActive,
  output logic              flashWrEn,
  output logic              bankingLive,
  output logic              cartOff,
  output logic              regEnable,
  output logic              extMode,
  output logic              clockPortEn,
  output logic              ioBankEn,
  output logic              freezeOff,
  output logic              mmcOff,
  output logic              ioWinLow,
  output logic              map16k,
  output logic              ramMode,
  output logic              biosOff
);

  logic       gameQ, exromQ, ramSelQ, forbidQ;
  logic [2:0] bankLo, bankHi;
  logic       cardDesel, fastSpi, readTrig;

  // main and extension control, freeze state
  always_ff @(posedge clk) begin
    if (rst) begin
      gameQ        <= 1'b0;
      exromQ       <= 1'b0;
      cartOff      <= 1'b0;
      bankLo       <= '0;
      ramSelQ      <= 1'b0;
      freezeActive <= 1'b0;
      clockPortEn  <= 1'b0;
      ioBankEn     <= 1'b0;
      freezeOff    <= 1'b0;
      mmcOff       <= 1'b0;
      ioWinLow     <= 1'b0;
    end else begin
      if (strobe.wrMain) begin
        gameQ   <= wrData[0];
        exromQ  <= wrData[1];
        cartOff <= wrData[2];
        bankLo  <= {wrData[7], wrData[4], wrData[3]};
        ramSelQ <= wrData[5];
        if (wrData[6]) freezeActive <= 1'b0;
      end
      if (strobe.wrExt) begin
        clockPortEn <= wrData[0];
        ioBankEn    <= wrData[1];
        freezeOff   <= wrData[2];
        bankLo      <= {wrData[7], wrData[4], wrData[3]};
        ioWinLow    <= wrData[6];
        if (extMode) mmcOff <= wrData[5];
      end
      if (strobe.wrStat && wrData[6]) cartOff <= 1'b0;
      if (strobe.freezeGo) begin
        freezeActive <= 1'b1;
        bankLo       <= '0;
        ramSelQ      <= 1'b0;
      end
    end
  end

  // card control, status and extended bank registers
  always_ff @(posedge clk) begin
    if (rst) begin
      biosOff   <= 1'b0;
      cardDesel <= 1'b0;
      fastSpi   <= 1'b0;
      ramMode   <= 1'b0;
      readTrig  <= 1'b0;
      forbidQ   <= 1'b0;
      extMode   <= 1'b0;
      bankHi    <= '0;
      map16k    <= 1'b0;
      regEnable <= 1'b0;
    end else begin
      if (strobe.wrCard) begin
        biosOff   <= wrData[0];
        cardDesel <= wrData[1];
        fastSpi   <= wrData[2];
        ramMode   <= wrData[5];
        readTrig  <= wrData[6];
      end
      if (strobe.wrStat) begin
        if (wrData[0]) forbidQ <= 1'b1;
        extMode <= wrData[6];
      end
      if (strobe.wrBank) begin
        bankHi    <= wrData[2:0];
        map16k    <= wrData[5];
        regEnable <= wrData[6];
      end
    end
  end

  always_comb begin
    bankingLive = regEnable & ~cartOff;
    flashWrEn   = ~forbidQ;
    gameLine    = bankingLive & gameQ;
    exromLine   = bankingLive & exromQ;
    ramOn       = bankingLive & (ramSelQ | freezeActive);
    bankAddr    = '0;
    if (bankingLive) bankAddr = {bankHi, bankLo[2:1], bankLo[0] & ~map16k};
  end

  always_comb begin
    unique case (rdSel)
      RD_CTRL: rdData = {bankLo[2], ioWinLow, 1'b0, bankLo[1], bankLo[0],
                         btnLevel, ioBankEn, ~forbidQ};
      RD_CARD: rdData = {1'b0, readTrig, ramMode, 2'b00, fastSpi, cardDesel, biosOff};
      RD_STAT: rdData = {5'b00000, exromQ, gameQ, 1'b0};
      RD_BANK: rdData = {1'b0, regEnable, map16k, 2'b00, bankHi};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] MAIN_ADR = 'h000,
  parameter logic [ADDR_W-1:0] CARD_ADR = 'h111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ioSel,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdHit,
  input  logic              freezeBtn,
  output logic              gameLine,
  output logic              exromLine,
  output logic [5:0]        bankAddr,
  output logic              ramOn,
  output logic              freezeActive,
  output logic              flashWrEn,
  output logic              bankingLive,
  output logic              cartOff,
  output logic              clockPortEn,
  output logic              ioBankEn,
  output logic              freezeOff,
  output logic              mmcOff,
  output logic              ioWinLow,
  output logic              map16k,
  output logic              ramMode,
  output logic              biosOff
);

  strobes_t strobe;
  rdSel_e   rdSel;
  logic     btnLevel, regEnable, extMode;

  cbr_ctrl #(
    .ADDR_W  (ADDR_W),
    .MAIN_ADR(MAIN_ADR),
    .CARD_ADR(CARD_ADR)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ioSel       (ioSel),
    .ioWr        (ioWr),
    .ioRd        (ioRd),
    .ioAddr      (ioAddr),
    .freezeBtn   (freezeBtn),
    .cartOff     (cartOff),
    .regEnable   (regEnable),
    .mmcOff      (mmcOff),
    .extMode     (extMode),
    .freezeOff   (freezeOff),
    .freezeActive(freezeActive),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .btnLevel    (btnLevel)
  );

  cbr_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .btnLevel    (btnLevel),
    .wrData      (wrData),
    .rdData      (rdData),
    .gameLine    (gameLine),
    .exromLine   (exromLine),
    .bankAddr    (bankAddr),
    .ramOn       (ramOn),
    .freezeActive(freezeActive),
    .flashWrEn   (flashWrEn),
    .bankingLive (bankingLive),
    .cartOff     (cartOff),
    .regEnable   (regEnable),
    .extMode     (extMode),
    .clockPortEn (clockPortEn),
    .ioBankEn    (ioBankEn),
    .freezeOff   (freezeOff),
    .mmcOff      (mmcOff),
    .ioWinLow    (ioWinLow),
    .map16k      (map16k),
    .ramMode     (ramMode),
    .biosOff     (biosOff)
  );

  assign rdHit = (rdSel != RD_NONE);

endmodule

// File: rtl/cart_bank_regs_chk.sv
module cart_bank_regs_chk #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] MAIN_ADR = 'h000,
  parameter logic [ADDR_W-1:0] CARD_ADR = 'h111
) (
  input logic              clk,
  input logic              rst,
  input logic              ioSel,
  input logic              ioWr,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              wrBit6,
  input logic              freezeBtn,
  input logic              freezeActive,
  input logic              freezeOff,
  input logic              flashWrEn,
  input logic              bankingLive,
  input logic              gameLine,
  input logic              exromLine,
  input logic [5:0]        bankAddr,
  input logic              ramOn,
  input logic              cartOff,
  input logic              mmcOff,
  input logic              map16k
);

  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(CARD_ADR + 1);

  logic exitWr, statSet;
  assign exitWr  = ioSel && ioWr && (ioAddr == MAIN_ADR) && wrBit6 && bankingLive;
  assign statSet = ioSel && ioWr && (ioAddr == STAT_ADR) && wrBit6 && !mmcOff;

  // R7: flash-write forbid cannot be undone without reset
  a_r7_forbid_sticky: assert property (@(posedge clk) disable iff (rst)
    !flashWrEn |=> !flashWrEn);

  // R9: entering freeze clears bank bits 13..15 and forces RAM on
  a_r9_freeze_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(freezeActive) |-> (bankAddr[2:0] == 3'b000) && (ramOn == bankingLive));

  // R10: entry only follows a button press with freeze enabled
  a_r10_entry_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(freezeActive) |-> $past(freezeBtn) && !$past(freezeOff));

  // R11: freeze holds until an exit write
  a_r11_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    freezeActive && !exitWr |=> freezeActive);

  // R8: status write with bit6 set re-enables the cartridge
  a_r8_status_clears: assert property (@(posedge clk) disable iff (rst)
    statSet |=> !cartOff);

  // R12: no banking outputs while banking is not live
  a_r12_gate: assert property (@(posedge clk) disable iff (rst)
    !bankingLive |-> !gameLine && !exromLine && !ramOn && (bankAddr == 6'd0));

  // R13: 16K mode masks bank bit 13
  a_r13_mask16k: assert property (@(posedge clk) disable iff (rst)
    map16k |-> !bankAddr[0]);

endmodule

bind cart_bank_regs cart_bank_regs_chk #(
  .ADDR_W  (ADDR_W),
  .MAIN_ADR(MAIN_ADR),
  .CARD_ADR(CARD_ADR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ioSel       (ioSel),
  .ioWr        (ioWr),
  .ioAddr      (ioAddr),
  .wrBit6      (wrData[6]),
  .freezeBtn   (freezeBtn),
  .freezeActive(freezeActive),
  .freezeOff   (freezeOff),
  .flashWrEn   (flashWrEn),
  .bankingLive (bankingLive),
  .gameLine    (gameLine),
  .exromLine   (exromLine),
  .bankAddr    (bankAddr),
  .ramOn       (ramOn),
  .cartOff     (cartOff),
  .mmcOff      (mmcOff),
  .map16k      (map16k)
);

// File: tb/cart_bank_regs_bench.sv
module cart_bank_regs_bench;

  localparam logic [8:0] A_MAIN = 9'h000;
  localparam logic [8:0] A_EXT  = 9'h001;
  localparam logic [8:0] A_CARD = 9'h111;
  localparam logic [8:0] A_STAT = 9'h112;
  localparam logic [8:0] A_BANK = 9'h113;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ioSel = 1'b0, ioWr = 1'b0, ioRd = 1'b0;
  logic [8:0] ioAddr = '0;
  logic [7:0] wrData = '0;
  logic       freezeBtn = 1'b0;
  logic [7:0] rdData;
  logic       rdHit, gameLine, exromLine, ramOn, freezeActive, flashWrEn;
  logic       bankingLive, cartOff, clockPortEn, ioBankEn, freezeOff, mmcOff;
  logic       ioWinLow, map16k, ramMode, biosOff;
  logic [5:0] bankAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cart_bank_regs u_cart_bank_regs (
    .clk(clk), .rst(rst), .ioSel(ioSel), .ioWr(ioWr), .ioRd(ioRd),
    .ioAddr(ioAddr), .wrData(wrData), .rdData(rdData), .rdHit(rdHit),
    .freezeBtn(freezeBtn), .gameLine(gameLine), .exromLine(exromLine),
    .bankAddr(bankAddr), .ramOn(ramOn), .freezeActive(freezeActive),
    .flashWrEn(flashWrEn), .bankingLive(bankingLive), .cartOff(cartOff),
    .clockPortEn(clockPortEn), .ioBankEn(ioBankEn), .freezeOff(freezeOff),
    .mmcOff(mmcOff), .ioWinLow(ioWinLow), .map16k(map16k),
    .ramMode(ramMode), .biosOff(biosOff)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    ioSel = 1'b1; ioWr = 1'b1; ioAddr = a; wrData = d;
    @(negedge clk);
    ioSel = 1'b0; ioWr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] v, output logic hit);
    @(negedge clk);
    ioSel = 1'b1; ioRd = 1'b1; ioAddr = a;
    #1;
    v = rdData; hit = rdHit;
    ioSel = 1'b0; ioRd = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [7:0] v, v2;
    logic       h, h2;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 game", gameLine, 0);
    chk("R1 exrom", exromLine, 0);
    chk("R1 bankAddr", bankAddr, 0);
    chk("R1 ramOn", ramOn, 0);
    chk("R1 freeze", freezeActive, 0);
    chk("R1 flashWrEn", flashWrEn, 1);
    chk("R1 freezeOff", freezeOff, 0);
    rd(A_STAT, v, h);
    chk("R1 status read", {h, v}, {1'b1, 8'h00});

    // R2 control hidden until register enable
    rd(A_MAIN, v, h);
    chk("R2 hidden hit", h, 0);
    wr(A_MAIN, 8'hFF);
    chk("R2 ignored write game", gameLine, 0);
    rd(A_BANK, v, h);
    chk("R6 bank hidden w/o ext mode", h, 0);
    wr(A_STAT, 8'h40);
    wr(A_BANK, 8'h40);
    chk("R2 live", bankingLive, 1);
    rd(A_MAIN, v, h);
    chk("R2 ctrl after ignored write", {h, v}, {1'b1, 8'h01});

    // R3 / R12 / R14 / R8 sweep of main control
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i);
      wr(A_MAIN, d);
      rd(A_STAT, v, h);
      chk("R14 status", {h, v}, {1'b1, 5'b0, d[1], d[0], 1'b0});
      if (d[2]) begin
        chk("R12 off game", gameLine, 0);
        chk("R12 off bank", bankAddr, 0);
        chk("R12 off ram", ramOn, 0);
        rd(A_MAIN, v, h);
        chk("R2 off hit", h, 0);
        wr(A_STAT, 8'h40);
        chk("R8 cartOff cleared", cartOff, 0);
      end else begin
        chk("R3 game", gameLine, d[0]);
        chk("R3 exrom", exromLine, d[1]);
        chk("R3 ram", ramOn, d[5]);
        chk("R3 bank", bankAddr, {3'b000, d[7], d[4], d[3]});
        rd(A_MAIN, v, h);
        chk("R3 read", {h, v}, {1'b1, d[7], 1'b0, 1'b0, d[4], d[3], 3'b001});
      end
    end

    // R4 / R5 sweep of extension control
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i);
      wr(A_EXT, d);
      chk("R4 clockport", clockPortEn, d[0]);
      chk("R4 iobank", ioBankEn, d[1]);
      chk("R4 freezeOff", freezeOff, d[2]);
      chk("R4 winlow", ioWinLow, d[6]);
      chk("R5 mmcOff", mmcOff, d[5]);
      rd(A_MAIN, v, h);
      rd(A_EXT, v2, h2);
      chk("R4 read main", {h, v}, {1'b1, d[7], d[6], 1'b0, d[4], d[3], 1'b0, d[1], 1'b1});
      chk("R4 mirror", {h2, v2}, {h, v});
      if (d[5]) begin
        rd(A_STAT, v, h);
        chk("R5 group hidden", h, 0);
        wr(A_STAT, 8'h01);
        chk("R5 hidden write ignored", flashWrEn, 1);
        wr(A_EXT, 8'h00);
      end
    end

    // R5 lock while extended mode is 0
    wr(A_STAT, 8'h00);
    wr(A_EXT, 8'h20);
    chk("R5 locked", mmcOff, 0);
    wr(A_BANK, 8'h00);
    chk("R6 bank write ignored", bankingLive, 1);
    wr(A_STAT, 8'h40);

    // R6 extended bank register
    wr(A_BANK, 8'h47);
    rd(A_BANK, v, h);
    chk("R6 read", {h, v}, {1'b1, 8'h47});
    wr(A_BANK, 8'hFF);
    rd(A_BANK, v, h);
    chk("R6 zero bits", v, 8'h67);

    // R13 16K masking
    wr(A_MAIN, 8'h08);
    chk("R13 masked", bankAddr, 6'h38);
    rd(A_MAIN, v, h);
    chk("R13 stored", v[3], 1);
    wr(A_BANK, 8'h47);
    chk("R13 unmasked", bankAddr, 6'h39);

    // R9 freeze entry
    wr(A_MAIN, 8'hB8);
    wr(A_CARD, 8'h20);
    chk("R9 pre bank", bankAddr, 6'h3F);
    @(negedge clk); freezeBtn = 1'b1;
    @(negedge clk);
    chk("R9 active", freezeActive, 1);
    chk("R9 bank cleared", bankAddr, 6'h38);
    chk("R9 ram forced", ramOn, 1);
    chk("R9 ram mode kept", ramMode, 1);
    rd(A_MAIN, v, h);
    chk("R9 read", v, 8'h05);

    // R10 no re-entry while active
    wr(A_MAIN, 8'h08);
    @(negedge clk); freezeBtn = 1'b0;
    @(negedge clk); freezeBtn = 1'b1;
    @(negedge clk);
    chk("R10 active repress", bankAddr, 6'h39);
    chk("R10 ram still forced", ramOn, 1);

    // R11 exit
    wr(A_MAIN, 8'h40);
    chk("R11 exit", freezeActive, 0);
    chk("R11 ram off", ramOn, 0);
    repeat (3) @(negedge clk);
    chk("R10 held level", freezeActive, 0);

    // R10 disabled freeze
    freezeBtn = 1'b0;
    wr(A_EXT, 8'h04);
    @(negedge clk); freezeBtn = 1'b1;
    @(negedge clk);
    chk("R10 disabled", freezeActive, 0);
    freezeBtn = 1'b0;
    wr(A_EXT, 8'h00);

    // R9 freeze wins over same-cycle write
    @(negedge clk);
    freezeBtn = 1'b1; ioSel = 1'b1; ioWr = 1'b1; ioAddr = A_MAIN; wrData = 8'h03;
    @(negedge clk);
    ioSel = 1'b0; ioWr = 1'b0;
    chk("R9 priority active", freezeActive, 1);
    chk("R9 write dropped", gameLine, 0);
    wr(A_MAIN, 8'h40);
    freezeBtn = 1'b0;

    // R7 sticky forbid
    wr(A_STAT, 8'h41);
    chk("R7 forbid", flashWrEn, 0);
    wr(A_STAT, 8'h40);
    chk("R7 sticky", flashWrEn, 0);
    rd(A_MAIN, v, h);
    chk("R7 read bit0", v[0], 0);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset flashWrEn", flashWrEn, 1);
    chk("R1 reset live", bankingLive, 0);
    chk("R1 reset mmcOff", mmcOff, 0);
    rd(A_MAIN, v, h);
    chk("R1 reset ctrl hidden", h, 0);

    done = 1;
    summary();
  end

endmodule